// File: doc/BRIEF.md
# SPI Configuration Register Slave

This block lets a host processor program a small map of 8-bit configuration registers over a serial link. The block is always the slave. Each transaction opens when chip select goes low. It starts with a 16-bit instruction word that carries a read/write flag, a two-bit byte count and a 13-bit register address. One or more data bytes follow, at consecutive increasing addresses. In streaming mode the bytes continue up to a programmable end address.

The serial inputs are resampled in the block's own clock domain. Edges of the serial clock are detected there, so the serial clock has to be several times slower than the system clock. The host can switch the bit order of later transactions between most-significant-first and least-significant-first. It can also move read data from the shared data line (three-wire) to a dedicated output (four-wire). The register map holds a read-only chip identifier and revision, a self-clearing soft reset, an override for the pin-selected clock divisor and an output-format code.

Top module: `cfg_spi_slave`

## Requirements
- R1: The instruction is 16 bits: bit 15 is the direction (1 = read, 0 = write), bits 14:13 are the byte count W and bits 12:0 are the address. In the default bit order the host sends bit 15 first and data bytes bit 7 first. The slave samples the data line on rising serial-clock edges (the clock idles low) and launches read bits on falling edges.
- R2: W values of 0, 1 and 2 transfer 1, 2 and 3 bytes at increasing addresses. Clocks after the last byte are ignored and do not drive the data line.
- R3: W = 3 streams bytes at increasing addresses. The byte at the address in the burst-end register (address 0x10, default 0xFF, compared with address bits 12:8 zero) is the last one transferred. Later bytes are neither written nor driven.
- R4: Configuration register 0x00 bit 0 selects least-significant-first order. In that order the instruction goes from bit 0 (A0) up to bit 15 (the direction flag) and data bytes go bit 0 first. The setting applies from the next transaction on.
- R5: Three-wire mode (register 0x00 bit 2 = 0, the default): read data appears on `sdio_out`, and `sdio_oe` is high only while read data bits are launched. It is low during the instruction, after the last byte and for writes. `sdo_oe` stays low.
- R6: Four-wire mode (register 0x00 bit 2 = 1): read data appears on `sdo_out` with `sdo_oe` high, and `sdio_oe` stays low.
- R7: Address 0x08 reads the chip identifier (default 0xA5) and address 0x09 reads the revision (default 0x01). Writes to either address are ignored.
- R8: Writing register 0x00 with bit 1 set returns every writable register to its default. Bit 1 always reads back as 0.
- R9: Register 0x72 bits 1:0 control `clk_div2`: 0 or 3 follows `clkdiv_pin`, 1 forces divide-by-1 (`clk_div2` = 0) and 2 forces divide-by-2 (`clk_div2` = 1).
- R10: Register 0x74 bits 2:0 drive `out_mode`. Only the codes 000 (pin control), 001 (differential, low current), 010 (differential, high current) and 100 (single-ended) are stored. A write of a reserved code leaves the register unchanged.
- R11: Raising chip select in the middle of a byte ends the transaction. The partial byte is not written and the data outputs are released.
- R12: After reset all registers hold their defaults, both output enables are low, `out_mode` is 000, and unmapped addresses read as 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_csn | input | 1 | Chip select, active low |
| spi_sclk | input | 1 | Serial clock from host, idles low |
| sdio_in | input | 1 | Serial data line as seen by the slave |
| sdio_out | output | 1 | Read data for the shared data line (three-wire) |
| sdio_oe | output | 1 | Drive enable for the shared data line |
| sdo_out | output | 1 | Read data for the dedicated output (four-wire) |
| sdo_oe | output | 1 | Drive enable for the dedicated output |
| clkdiv_pin | input | 1 | Pin-selected divisor, 1 = divide by 2 |
| clk_div2 | output | 1 | Resolved divisor, 1 = divide by 2 |
| out_mode | output | 3 | Stored output-format code |

## Verification
Register access is tried with single-byte, two- and three-byte, and streaming transfers. Comparing the bytes and output enables at each byte slot shows whether the byte count and the burst-end stop are decoded correctly. The same accesses repeated in reversed bit order, and with four-wire output, separate a field or bit-order mistake from a routing mistake between the two data outputs. Reserved output codes, writes to read-only addresses, a transfer aborted after five bits and a soft reset each have a distinct visible result at the ports: a changed register value or readback.

// File: rtl/cfg_spi_pkg.sv
package cfg_spi_pkg;

    localparam int ADDR_W  = 13;
    localparam int BYTE_W  = 8;
    localparam int INSTR_W = 16;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_INSTR,
        PH_DATA,
        PH_DONE
    } phase_e;

    localparam logic [ADDR_W-1:0] A_CFG    = 13'h000;
    localparam logic [ADDR_W-1:0] A_CHIPID = 13'h008;
    localparam logic [ADDR_W-1:0] A_CHIPVR = 13'h009;
    localparam logic [ADDR_W-1:0] A_BEND   = 13'h010;
    localparam logic [ADDR_W-1:0] A_CLKDIV = 13'h072;
    localparam logic [ADDR_W-1:0] A_OMODE  = 13'h074;

    typedef struct packed {
        logic        lsb;
        logic        four;
        logic [1:0]  clkdiv;
        logic [2:0]  omode;
        logic [7:0]  bend;
    } regs_t;

    localparam regs_t REGS_DEFAULT = '{lsb: 1'b0, four: 1'b0, clkdiv: 2'd0,
                                       omode: 3'd0, bend: 8'hFF};

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stg_d [STAGES];
    logic [WIDTH-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= RST_VAL;
            end
        end else begin
            stg_q <= stg_d;
        end
    end

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine
    import cfg_spi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csn_s,
    input  logic              sclk_s,
    input  logic              sdio_s,
    input  logic              lsb_cfg,
    input  logic              four_cfg,
    input  logic [BYTE_W-1:0] bend,
    input  logic [BYTE_W-1:0] rd_data,
    output logic [ADDR_W-1:0] acc_addr,
    output logic              wr_en,
    output logic [BYTE_W-1:0] wr_data,
    output logic              out_bit,
    output logic              drive,
    output logic              four_act
);
    typedef struct packed {
        phase_e              phase;
        logic [3:0]          cnt;
        logic [INSTR_W-1:0]  sh;
        logic [ADDR_W-1:0]   addr;
        logic [1:0]          left;
        logic                stream;
        logic                rd;
        logic                lsb;
        logic                four;
        logic                sclk_p;
        logic                load_pend;
        logic                drive;
        logic                obit;
        logic [BYTE_W-1:0]   tx;
    } eng_t;

    eng_t q, d;
    logic rise, fall, last;
    logic [INSTR_W-1:0] sh_in;
    logic [BYTE_W-1:0]  byte_in, src;

    always_comb begin
        d       = q;
        wr_en   = 1'b0;
        wr_data = '0;
        rise    = sclk_s & ~q.sclk_p;
        fall    = ~sclk_s & q.sclk_p;
        d.sclk_p = sclk_s;
        sh_in   = q.lsb ? {sdio_s, q.sh[INSTR_W-1:1]} : {q.sh[INSTR_W-2:0], sdio_s};
        byte_in = q.lsb ? sh_in[INSTR_W-1:INSTR_W-BYTE_W] : sh_in[BYTE_W-1:0];
        last    = q.stream ? (q.addr == {{(ADDR_W-BYTE_W){1'b0}}, bend}) : (q.left == 2'd0);
        src     = q.load_pend ? rd_data : q.tx;

        if (csn_s) begin
            d.phase     = PH_IDLE;
            d.cnt       = '0;
            d.drive     = 1'b0;
            d.load_pend = 1'b0;
        end else if (q.phase == PH_IDLE) begin
            d.phase     = PH_INSTR;
            d.cnt       = '0;
            d.lsb       = lsb_cfg;
            d.four      = four_cfg;
            d.drive     = 1'b0;
            d.load_pend = 1'b0;
        end else begin
            if (rise && (q.phase == PH_INSTR || q.phase == PH_DATA)) begin
                d.sh  = sh_in;
                d.cnt = q.cnt + 4'd1;
                if (q.phase == PH_INSTR && q.cnt == 4'd15) begin
                    d.phase     = PH_DATA;
                    d.cnt       = '0;
                    d.rd        = sh_in[15];
                    d.left      = sh_in[14:13];
                    d.stream    = (sh_in[14:13] == 2'b11);
                    d.addr      = sh_in[ADDR_W-1:0];
                    d.load_pend = sh_in[15];
                end else if (q.phase == PH_DATA && q.cnt == 4'd7) begin
                    d.cnt = '0;
                    if (!q.rd) begin
                        wr_en   = 1'b1;
                        wr_data = byte_in;
                    end
                    if (last) begin
                        d.phase = PH_DONE;
                        d.drive = 1'b0;
                    end else begin
                        d.addr      = q.addr + 13'd1;
                        d.left      = q.left - 2'd1;
                        d.load_pend = q.rd;
                    end
                end
            end
            if (fall && q.phase == PH_DATA && q.rd) begin
                d.obit      = q.lsb ? src[0] : src[BYTE_W-1];
                d.tx        = q.lsb ? {1'b0, src[BYTE_W-1:1]} : {src[BYTE_W-2:0], 1'b0};
                d.load_pend = 1'b0;
                d.drive     = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{phase: PH_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign acc_addr = q.addr;
    assign out_bit  = q.obit;
    assign drive    = q.drive;
    assign four_act = q.four;

    // R1
    write_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !q.rd);
    // R5
    drive_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.drive |-> (q.rd && q.phase == PH_DATA));
    // R11
    cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        csn_s |=> !q.drive);
endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
    import cfg_spi_pkg::*;
#(
    parameter logic [BYTE_W-1:0] CHIP_ID  = 8'hA5,
    parameter logic [BYTE_W-1:0] CHIP_VER = 8'h01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              clkdiv_pin,
    output logic [BYTE_W-1:0] rd_data,
    output logic              lsb_cfg,
    output logic              four_cfg,
    output logic [BYTE_W-1:0] bend,
    output logic              clk_div2,
    output logic [2:0]        out_mode
);
    regs_t regs_q, regs_d;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            case (addr)
                A_CFG: begin
                    if (wr_data[1]) begin
                        regs_d = REGS_DEFAULT;
                    end else begin
                        regs_d.lsb  = wr_data[0];
                        regs_d.four = wr_data[2];
                    end
                end
                A_BEND:   regs_d.bend   = wr_data;
                A_CLKDIV: regs_d.clkdiv = wr_data[1:0];
                A_OMODE: begin
                    if (wr_data[2:0] inside {3'b000, 3'b001, 3'b010, 3'b100}) begin
                        regs_d.omode = wr_data[2:0];
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        case (addr)
            A_CFG:    rd_data = {5'b0, regs_q.four, 1'b0, regs_q.lsb};
            A_CHIPID: rd_data = CHIP_ID;
            A_CHIPVR: rd_data = CHIP_VER;
            A_BEND:   rd_data = regs_q.bend;
            A_CLKDIV: rd_data = {6'b0, regs_q.clkdiv};
            A_OMODE:  rd_data = {5'b0, regs_q.omode};
            default:  rd_data = '0;
        endcase
    end

    always_comb begin
        case (regs_q.clkdiv)
            2'd1:    clk_div2 = 1'b0;
            2'd2:    clk_div2 = 1'b1;
            default: clk_div2 = clkdiv_pin;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= REGS_DEFAULT;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign lsb_cfg  = regs_q.lsb;
    assign four_cfg = regs_q.four;
    assign bend     = regs_q.bend;
    assign out_mode = regs_q.omode;

    // R10
    omode_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        regs_q.omode inside {3'b000, 3'b001, 3'b010, 3'b100});
    // R8
    soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_CFG && wr_data[1]) |=> (regs_q == REGS_DEFAULT));
    // R7
    readonly_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (addr == A_CHIPID || addr == A_CHIPVR)) |=> $stable(regs_q));
endmodule

// File: rtl/cfg_spi_slave.sv
module cfg_spi_slave
    import cfg_spi_pkg::*;
#(
    parameter int                SYNC_STAGES = 2,
    parameter logic [BYTE_W-1:0] CHIP_ID     = 8'hA5,
    parameter logic [BYTE_W-1:0] CHIP_VER    = 8'h01
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       spi_csn,
    input  logic       spi_sclk,
    input  logic       sdio_in,
    output logic       sdio_out,
    output logic       sdio_oe,
    output logic       sdo_out,
    output logic       sdo_oe,
    input  logic       clkdiv_pin,
    output logic       clk_div2,
    output logic [2:0] out_mode
);
    logic [2:0]        sync_out;
    logic [ADDR_W-1:0] acc_addr;
    logic              wr_en, lsb_cfg, four_cfg, out_bit, drive, four_act;
    logic [BYTE_W-1:0] wr_data, rd_data, bend;

    spi_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) i_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({spi_csn, spi_sclk, sdio_in}),
        .dout (sync_out)
    );

    spi_frame_engine i_engine (
        .clk     (clk),
        .rst_n   (rst_n),
        .csn_s   (sync_out[2]),
        .sclk_s  (sync_out[1]),
        .sdio_s  (sync_out[0]),
        .lsb_cfg (lsb_cfg),
        .four_cfg(four_cfg),
        .bend    (bend),
        .rd_data (rd_data),
        .acc_addr(acc_addr),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .out_bit (out_bit),
        .drive   (drive),
        .four_act(four_act)
    );

    cfg_regfile #(.CHIP_ID(CHIP_ID), .CHIP_VER(CHIP_VER)) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (acc_addr),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .clkdiv_pin(clkdiv_pin),
        .rd_data   (rd_data),
        .lsb_cfg   (lsb_cfg),
        .four_cfg  (four_cfg),
        .bend      (bend),
        .clk_div2  (clk_div2),
        .out_mode  (out_mode)
    );

    assign sdio_out = out_bit;
    assign sdo_out  = out_bit;
    assign sdio_oe  = drive & ~four_act;
    assign sdo_oe   = drive & four_act;

    // R6
    single_driver_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(sdio_oe && sdo_oe));
endmodule

// File: tb/test_cfg_spi_slave.sv
module test_cfg_spi_slave;
    localparam int HALF = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic spi_csn = 1'b1;
    logic spi_sclk = 1'b0;
    logic clkdiv_pin = 1'b0;
    logic tb_sdio = 1'b0;
    logic tb_oe = 1'b0;
    logic sdio_in, sdio_out, sdio_oe, sdo_out, sdo_oe, clk_div2;
    logic [2:0] out_mode;

    logic lsb_mode = 1'b0;
    logic four_mode = 1'b0;
    int n_checks = 0;
    int n_fail = 0;
    int oe_instr = 0;
    int sdio_oe_seen = 0;

    always #4 clk = ~clk;

    assign sdio_in = sdio_oe ? sdio_out : (tb_oe ? tb_sdio : 1'b1);

    cfg_spi_slave i_cfg_spi_slave (
        .clk(clk), .rst_n(rst_n), .spi_csn(spi_csn), .spi_sclk(spi_sclk),
        .sdio_in(sdio_in), .sdio_out(sdio_out), .sdio_oe(sdio_oe),
        .sdo_out(sdo_out), .sdo_oe(sdo_oe), .clkdiv_pin(clkdiv_pin),
        .clk_div2(clk_div2), .out_mode(out_mode)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_half();
        repeat (HALF) @(negedge clk);
    endtask

    task automatic bit_xfer(input logic b, output logic seen, output logic oe);
        tb_sdio = b;
        wait_half();
        seen = four_mode ? sdo_out : sdio_in;
        oe   = four_mode ? sdo_oe : sdio_oe;
        if (sdio_oe) sdio_oe_seen++;
        spi_sclk = 1'b1;
        wait_half();
        spi_sclk = 1'b0;
    endtask

    task automatic cs_start();
        spi_csn = 1'b0;
        tb_oe = 1'b1;
        wait_half();
    endtask

    task automatic cs_stop();
        wait_half();
        spi_csn = 1'b1;
        tb_oe = 1'b0;
        repeat (4) wait_half();
    endtask

    task automatic send_instr(input logic rw, input logic [1:0] w, input logic [12:0] addr);
        logic [15:0] word;
        logic s, o;
        word = {rw, w, addr};
        oe_instr = 0;
        for (int i = 0; i < 16; i++) begin
            bit_xfer(lsb_mode ? word[i] : word[15-i], s, o);
            if (sdio_oe || sdo_oe) oe_instr++;
        end
        if (rw) tb_oe = 1'b0;
    endtask

    task automatic xfer_byte(input logic [7:0] din, output logic [7:0] dout, output int oe_cnt);
        logic s, o;
        int idx;
        oe_cnt = 0;
        for (int i = 0; i < 8; i++) begin
            idx = lsb_mode ? i : 7 - i;
            bit_xfer(din[idx], s, o);
            dout[idx] = s;
            if (o) oe_cnt++;
        end
    endtask

    task automatic wr1(input logic [12:0] addr, input logic [7:0] data);
        logic [7:0] r;
        int c;
        cs_start();
        send_instr(1'b0, 2'd0, addr);
        xfer_byte(data, r, c);
        cs_stop();
    endtask

    task automatic rd1(input logic [12:0] addr, output logic [7:0] data, output int oe_cnt);
        cs_start();
        send_instr(1'b1, 2'd0, addr);
        xfer_byte(8'h00, data, oe_cnt);
        cs_stop();
    endtask

    task automatic test_reset();
        clkdiv_pin = 1'b1;
        wait_half();
        check("R12 out_mode after reset", out_mode, 3'b000);
        check("R12 sdio_oe after reset", sdio_oe, 1'b0);
        check("R12 sdo_oe after reset", sdo_oe, 1'b0);
        check("R9 clk_div2 follows pin at reset", clk_div2, 1'b1);
    endtask

    task automatic test_single();
        logic [7:0] r;
        int c;
        wr1(13'h074, 8'h01);
        check("R1 out_mode after single write", out_mode, 3'b001);
        rd1(13'h074, r, c);
        check("R1 single read value", r, 8'h01);
        check("R5 sdio_oe during read data bits", c, 8);
        check("R5 sdio_oe low during instruction", oe_instr, 0);
        check("R5 sdio_oe low after read", sdio_oe, 1'b0);
        rd1(13'h155, r, c);
        check("R12 unmapped address reads zero", r, 8'h00);
    endtask

    task automatic test_reserved();
        wr1(13'h074, 8'h03);
        check("R10 reserved code 011 ignored", out_mode, 3'b001);
        wr1(13'h074, 8'h07);
        check("R10 reserved code 111 ignored", out_mode, 3'b001);
        wr1(13'h074, 8'h02);
        check("R10 code 010 stored", out_mode, 3'b010);
    endtask

    task automatic test_clkdiv();
        clkdiv_pin = 1'b1;
        wr1(13'h072, 8'h01);
        check("R9 override 1 forces divide-by-1", clk_div2, 1'b0);
        clkdiv_pin = 1'b0;
        wr1(13'h072, 8'h02);
        check("R9 override 2 forces divide-by-2", clk_div2, 1'b1);
        wr1(13'h072, 8'h03);
        check("R9 override 3 follows pin", clk_div2, 1'b0);
    endtask

    task automatic test_multi();
        logic [7:0] r;
        int c;
        cs_start();
        send_instr(1'b0, 2'd2, 13'h072);
        xfer_byte(8'h02, r, c);
        xfer_byte(8'hEE, r, c);
        xfer_byte(8'h04, r, c);
        cs_stop();
        check("R2 three-byte write first byte", clk_div2, 1'b1);
        check("R2 three-byte write third byte", out_mode, 3'b100);
        cs_start();
        send_instr(1'b1, 2'd1, 13'h072);
        xfer_byte(8'h00, r, c);
        check("R2 two-byte read byte 0", r, 8'h02);
        xfer_byte(8'h00, r, c);
        check("R2 two-byte read byte 1", r, 8'h00);
        check("R2 oe on byte 1", c, 8);
        xfer_byte(8'h00, r, c);
        check("R2 no drive after last byte", c, 0);
        cs_stop();
    endtask

    task automatic test_stream();
        logic [7:0] r;
        int c;
        wr1(13'h010, 8'h73);
        cs_start();
        send_instr(1'b1, 2'd3, 13'h072);
        xfer_byte(8'h00, r, c);
        check("R3 stream read byte 0", r, 8'h02);
        xfer_byte(8'h00, r, c);
        check("R3 stream read at burst end oe", c, 8);
        xfer_byte(8'h00, r, c);
        check("R3 stream stops after burst end", c, 0);
        cs_stop();
        clkdiv_pin = 1'b1;
        cs_start();
        send_instr(1'b0, 2'd3, 13'h072);
        xfer_byte(8'h01, r, c);
        xfer_byte(8'h55, r, c);
        xfer_byte(8'h01, r, c);
        cs_stop();
        check("R3 stream write first byte", clk_div2, 1'b0);
        check("R3 stream write past end ignored", out_mode, 3'b100);
    endtask

    task automatic test_readonly();
        logic [7:0] r;
        int c;
        wr1(13'h008, 8'h12);
        wr1(13'h009, 8'h34);
        rd1(13'h008, r, c);
        check("R7 chip id after write", r, 8'hA5);
        rd1(13'h009, r, c);
        check("R7 revision after write", r, 8'h01);
    endtask

    task automatic test_lsb();
        logic [7:0] r;
        int c;
        wr1(13'h000, 8'h01);
        lsb_mode = 1'b1;
        wr1(13'h074, 8'h02);
        check("R4 lsb-first write", out_mode, 3'b010);
        rd1(13'h074, r, c);
        check("R4 lsb-first read", r, 8'h02);
        rd1(13'h000, r, c);
        check("R4 cfg readback", r, 8'h01);
    endtask

    task automatic test_four();
        logic [7:0] r;
        int c;
        wr1(13'h000, 8'h05);
        four_mode = 1'b1;
        sdio_oe_seen = 0;
        rd1(13'h074, r, c);
        check("R6 four-wire read value", r, 8'h02);
        check("R6 sdo_oe during read", c, 8);
        check("R6 sdio_oe stays low", sdio_oe_seen, 0);
    endtask

    task automatic test_softreset();
        logic [7:0] r;
        int c;
        clkdiv_pin = 1'b1;
        wr1(13'h000, 8'h02);
        lsb_mode = 1'b0;
        four_mode = 1'b0;
        check("R8 out_mode default after soft reset", out_mode, 3'b000);
        check("R8 clkdiv default after soft reset", clk_div2, 1'b1);
        rd1(13'h000, r, c);
        check("R8 cfg reads zero", r, 8'h00);
        rd1(13'h010, r, c);
        check("R8 burst end default", r, 8'hFF);
    endtask

    task automatic test_abort();
        logic s, o;
        logic [7:0] r;
        int c;
        wr1(13'h074, 8'h04);
        cs_start();
        send_instr(1'b0, 2'd0, 13'h074);
        for (int i = 0; i < 5; i++) bit_xfer(1'b0, s, o);
        cs_stop();
        check("R11 partial byte not written", out_mode, 3'b100);
        check("R11 outputs released", sdio_oe | sdo_oe, 1'b0);
        cs_start();
        send_instr(1'b1, 2'd0, 13'h074);
        for (int i = 0; i < 3; i++) bit_xfer(1'b0, s, o);
        cs_stop();
        check("R11 oe released on read abort", sdio_oe, 1'b0);
        rd1(13'h074, r, c);
        check("R11 next transaction intact", r, 8'h04);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        test_reset();
        test_single();
        test_reserved();
        test_clkdiv();
        test_multi();
        test_stream();
        test_readonly();
        test_lsb();
        test_four();
        test_softreset();
        test_abort();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule